// File: doc/BRIEF.md
# Single-Cycle Stack Processor

This block is a compact 16-bit processor in which every operand lives on a hardware stack rather than in a register file. The two newest entries sit in registers called top and next. Older entries spill into a small circular array. Each clock cycle the core fetches one instruction from an internal word-addressed RAM and completes it in that same cycle. The RAM holds both code and data. The four high instruction bits choose the form:

- immediate push;
- push from or pop to a memory word;
- jump, jump-if-zero, jump-if-nonzero;
- the operand-free group, selected by major code 0xF.

The operand-free group holds the arithmetic and logic operations, load and store through the top entry, program-counter push and pop for subroutine linkage, stack shuffles, and port transfers.

The core talks to the surrounding logic through eight 16-bit input ports and eight 16-bit output ports.

- **Input ports:** level-sampled when an input instruction runs.
- **Output ports:** each holds its last written value and pulses a one-cycle strobe on the write.
- **No valid/ready handshake:** the ports carry no back-pressure. A consumer that cannot take a value at strobe time must latch it.
- **Halt input:** freezes execution with no side effects.
- **Preload port:** writes RAM words at any time and wins over a core write in the same cycle. Reset does not clear the RAM, so a test can load a program, pulse reset and let the core run from address 0.

Top module: `sm_cpu`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the program counter, the stack (all entries read as 0) and all output ports and strobes. Execution begins with the word at address 0 on the first clock edge with halt low.
- R2: Major code 0x1 pushes the low 12 bits sign-extended. Major 0x2 pushes mem[A]. Major 0x3 pops the top into mem[A]. A is the low AW bits of the instruction.
- R3: Major 0x4 jumps to A. Major 0x5 jumps when top is zero. Major 0x6 jumps when top is nonzero. Both conditional forms pop the tested entry whether or not they jump.
- R4: Word 0xF00k pops top and next and pushes next OP top. For k = 0 to 15 the operations are: add, sub, mul (low 16 bits), shift left, logical shift right, and, or, xor, logical and, logical or, equal, not equal, signed >=, signed <=, signed >, signed <.
  - Shift counts use the whole top value, so 16 or more gives 0.
  - Logical and comparison results are 1 or 0.
- R5: 0xF010 replaces the top with its two's-complement negation. 0xF011 replaces it with its bitwise inverse. 0xF012 replaces it with its logical not (1 if zero, else 0).
- R6: 0xF020 replaces the top with mem[top]. 0xF021 writes top into mem[next] and removes both entries.
- R7: 0xF022 pushes the address of the instruction after it. 0xF023 pops the top into the program counter.
- R8: 0xF024 duplicates top. 0xF025 drops top. 0xF026 pushes a copy of next. 0xF027 removes next and keeps top.
- R9: 0xF03n (n = 0 to 7) pushes input port n. 0xF04n pops top into output port n and raises strobe bit n for exactly one cycle. The port keeps the value until it is written again.
- R10: The stack holds DEPTH+2 entries in LIFO order. Pushing past that overwrites the oldest entries in circular order without any trap. Popping past empty reads whatever the circular array holds.
- R11: While halt is high the program counter, stack, RAM (except through the preload port) and output ports stay unchanged and no strobe fires.
- R12: A preload write (pl_we) stores pl_data at pl_addr on the clock edge. It takes priority over a core write, and its contents survive reset.
- R13: Major codes 0x0 and 0x7 to 0xE, and every 0xF word not listed above, only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes execution while high |
| in_data | input | 128 | Eight input ports, port n at bits 16n+15:16n |
| out_data | output | 128 | Eight output ports, port n at bits 16n+15:16n |
| out_stb | output | 8 | One-cycle write strobe per output port |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | AW | Preload word address |
| pl_data | input | 16 | Preload write data |

## Verification
The hardest state to reach from the ports is the circular spill array after it has wrapped. Only a program that pushes more than DEPTH+2 values and then folds them back with additions shows whether the overwritten slots come back in the right order. The bench builds such push chains and compares the folded sum with a bench model of the circular array. A halt that lands in the middle of a running loop is the second hard case. It is reached by stopping a counting program after a chosen number of cycles and checking that the count and strobes stay still until release.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int SM_DW    = 16;
  localparam int SM_NPORT = 8;

  localparam logic [3:0] MJ_PUSHI = 4'h1;
  localparam logic [3:0] MJ_PUSHM = 4'h2;
  localparam logic [3:0] MJ_POPM  = 4'h3;
  localparam logic [3:0] MJ_JMP   = 4'h4;
  localparam logic [3:0] MJ_JZ    = 4'h5;
  localparam logic [3:0] MJ_JNZ   = 4'h6;
  localparam logic [3:0] MJ_EXT   = 4'hF;

  localparam logic [3:0] GR_BIN  = 4'h0;
  localparam logic [3:0] GR_UNA  = 4'h1;
  localparam logic [3:0] GR_MISC = 4'h2;
  localparam logic [3:0] GR_IN   = 4'h3;
  localparam logic [3:0] GR_OUT  = 4'h4;

  typedef enum logic [2:0] {
    ST_HOLD, ST_PUSH, ST_REPL, ST_POP1, ST_POP2R, ST_POP2, ST_NIP
  } st_op_e;
endpackage

// File: rtl/sm_alu.sv
module sm_alu #(
  parameter int DW = 16
) (
  input  logic [4:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (fn)
      5'd0:  y = a + b;
      5'd1:  y = a - b;
      5'd2:  y = a * b;
      5'd3:  y = a << b;
      5'd4:  y = a >> b;
      5'd5:  y = a & b;
      5'd6:  y = a | b;
      5'd7:  y = a ^ b;
      5'd8:  y = DW'((a != '0) && (b != '0));
      5'd9:  y = DW'((a != '0) || (b != '0));
      5'd10: y = DW'(a == b);
      5'd11: y = DW'(a != b);
      5'd12: y = DW'($signed(a) >= $signed(b));
      5'd13: y = DW'($signed(a) <= $signed(b));
      5'd14: y = DW'($signed(a) >  $signed(b));
      5'd15: y = DW'($signed(a) <  $signed(b));
      5'd16: y = -b;
      5'd17: y = ~b;
      5'd18: y = DW'(b == '0);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/sm_stack.sv
module sm_stack
  import sm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  st_op_e        op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] tos,
  output logic [DW-1:0] nos
);
  localparam int SPW = $clog2(DEPTH);

  logic [DW-1:0]  spill_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] sp_m1, sp_m2;

  assign sp_m1 = sp_q - SPW'(1);
  assign sp_m2 = sp_q - SPW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos  <= '0;
      nos  <= '0;
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) spill_q[i] <= '0;
    end else if (en) begin
      case (op)
        ST_PUSH: begin
          spill_q[sp_q] <= nos;
          sp_q <= sp_q + SPW'(1);
          nos  <= tos;
          tos  <= wdata;
        end
        ST_REPL: tos <= wdata;
        ST_POP1: begin
          tos  <= nos;
          nos  <= spill_q[sp_m1];
          sp_q <= sp_m1;
        end
        ST_POP2R: begin
          tos  <= wdata;
          nos  <= spill_q[sp_m1];
          sp_q <= sp_m1;
        end
        ST_POP2: begin
          tos  <= spill_q[sp_m1];
          nos  <= spill_q[sp_m2];
          sp_q <= sp_m2;
        end
        ST_NIP: begin
          nos  <= spill_q[sp_m1];
          sp_q <= sp_m1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sm_ram.sv
module sm_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rda,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rdb
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rda = mem_q[ra];
  assign rdb = mem_q[rb];
endmodule

// File: rtl/sm_cpu.sv
module sm_cpu
  import sm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      halt,
  input  logic [SM_NPORT*SM_DW-1:0] in_data,
  output logic [SM_NPORT*SM_DW-1:0] out_data,
  output logic [SM_NPORT-1:0]       out_stb,
  input  logic                      pl_we,
  input  logic [AW-1:0]             pl_addr,
  input  logic [SM_DW-1:0]          pl_data
);
  localparam int DW = SM_DW;

  logic [AW-1:0] pc_q, pc_inc, pc_n, a_fld, rb_addr, cpu_waddr;
  logic [DW-1:0] instr, tos, nos, rd_b, alu_y, st_wd, cpu_wd, imm_sx, pc_ext;
  logic          cpu_we, out_en;
  st_op_e        st_op;
  logic [DW-1:0] out_q [SM_NPORT];

  assign pc_inc = pc_q + AW'(1);
  assign a_fld  = instr[AW-1:0];
  assign imm_sx = {{(DW-12){instr[11]}}, instr[11:0]};
  assign pc_ext = {{(DW-AW){1'b0}}, pc_inc};

  sm_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (pl_we | (cpu_we & ~halt)),
    .waddr (pl_we ? pl_addr : cpu_waddr),
    .wdata (pl_we ? pl_data : cpu_wd),
    .ra    (pc_q),
    .rda   (instr),
    .rb    (rb_addr),
    .rdb   (rd_b)
  );

  sm_alu #(.DW(DW)) u_alu (
    .fn (instr[4:0]),
    .a  (nos),
    .b  (tos),
    .y  (alu_y)
  );

  sm_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~halt),
    .op    (st_op),
    .wdata (st_wd),
    .tos   (tos),
    .nos   (nos)
  );

  always_comb begin
    st_op     = ST_HOLD;
    st_wd     = alu_y;
    pc_n      = pc_inc;
    cpu_we    = 1'b0;
    cpu_waddr = a_fld;
    cpu_wd    = tos;
    rb_addr   = a_fld;
    out_en    = 1'b0;
    case (instr[15:12])
      MJ_PUSHI: begin st_op = ST_PUSH; st_wd = imm_sx; end
      MJ_PUSHM: begin st_op = ST_PUSH; st_wd = rd_b; end
      MJ_POPM:  begin st_op = ST_POP1; cpu_we = 1'b1; end
      MJ_JMP:   pc_n = a_fld;
      MJ_JZ: begin
        st_op = ST_POP1;
        if (tos == '0) pc_n = a_fld;
      end
      MJ_JNZ: begin
        st_op = ST_POP1;
        if (tos != '0) pc_n = a_fld;
      end
      MJ_EXT: if (instr[11:8] == 4'h0) begin
        case (instr[7:4])
          GR_BIN: st_op = ST_POP2R;
          GR_UNA: if (instr[3:0] <= 4'h2) st_op = ST_REPL;
          GR_MISC: case (instr[3:0])
            4'h0: begin rb_addr = tos[AW-1:0]; st_op = ST_REPL; st_wd = rd_b; end
            4'h1: begin st_op = ST_POP2; cpu_we = 1'b1; cpu_waddr = nos[AW-1:0]; end
            4'h2: begin st_op = ST_PUSH; st_wd = pc_ext; end
            4'h3: begin st_op = ST_POP1; pc_n = tos[AW-1:0]; end
            4'h4: begin st_op = ST_PUSH; st_wd = tos; end
            4'h5: st_op = ST_POP1;
            4'h6: begin st_op = ST_PUSH; st_wd = nos; end
            4'h7: st_op = ST_NIP;
            default: ;
          endcase
          GR_IN: if (!instr[3]) begin
            st_op = ST_PUSH;
            st_wd = in_data[instr[2:0]*DW +: DW];
          end
          GR_OUT: if (!instr[3]) begin
            st_op  = ST_POP1;
            out_en = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      out_stb <= '0;
      for (int i = 0; i < SM_NPORT; i++) out_q[i] <= '0;
    end else begin
      out_stb <= '0;
      if (!halt) begin
        pc_q <= pc_n;
        if (out_en) begin
          out_q[instr[2:0]]   <= tos;
          out_stb[instr[2:0]] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < SM_NPORT; g++) begin : g_out
    assign out_data[g*DW +: DW] = out_q[g];
  end
endmodule

// File: rtl/sm_cpu_chk.sv
module sm_cpu_chk
  import sm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = SM_DW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                halt,
  input logic [DW-1:0]       instr,
  input logic [AW-1:0]       pc_q,
  input logic [DW-1:0]       tos,
  input logic [DW-1:0]       nos,
  input logic [SM_NPORT-1:0] out_stb
);
  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pc_q) && $stable(tos) && $stable(nos));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> out_stb == '0);

  // R9
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_stb));

  // R3
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[15:12] == 4'h4) |=> pc_q == $past(instr[AW-1:0]));

  // R3
  jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[15:12] == 4'h5 && tos == '0) |=> pc_q == $past(instr[AW-1:0]));

  // R2
  pushi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[15:12] == 4'h1) |=>
      (tos == $past({{(DW-12){instr[11]}}, instr[11:0]}) && nos == $past(tos)));

  // R13
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && (instr[15:12] <= 4'h3 || (instr[15:12] >= 4'h7 && instr[15:12] <= 4'hE)))
      |=> pc_q == AW'($past(pc_q) + AW'(1)));
endmodule

bind sm_cpu sm_cpu_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .halt    (halt),
  .instr   (instr),
  .pc_q    (pc_q),
  .tos     (tos),
  .nos     (nos),
  .out_stb (out_stb)
);

// File: tb/sm_cpu_tb.sv
module sm_cpu_tb;
  localparam int D  = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b1;
  logic [127:0] in_data = '0;
  logic [127:0] out_data;
  logic [7:0] out_stb;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [15:0] pl_data = '0;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, cyc = 0;
  logic [15:0] prog[$];

  sm_cpu #(.DEPTH(D), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .in_data(in_data),
    .out_data(out_data), .out_stb(out_stb),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (rst_n && out_stb != 0) stb_cnt++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] port(input int n);
    return out_data[n*16 +: 16];
  endfunction

  task automatic wr(input int a, input logic [15:0] w);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = AW'(a); pl_data = w;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic start(input bit h);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; halt = h;
  endtask

  task automatic run_prog(input int cycles);
    halt = 1'b1;
    foreach (prog[i]) wr(i, prog[i]);
    start(1'b0);
    repeat (cycles) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] ref_bin(input int k, input logic [15:0] a, input logic [15:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      3: return a << b;
      4: return a >> b;
      5: return a & b;
      6: return a | b;
      7: return a ^ b;
      8: return {15'd0, (a != 0) && (b != 0)};
      9: return {15'd0, (a != 0) || (b != 0)};
      10: return {15'd0, a == b};
      11: return {15'd0, a != b};
      12: return {15'd0, $signed(a) >= $signed(b)};
      13: return {15'd0, $signed(a) <= $signed(b)};
      14: return {15'd0, $signed(a) > $signed(b)};
      default: return {15'd0, $signed(a) < $signed(b)};
    endcase
  endfunction

  function automatic logic [15:0] ref_una(input int k, input logic [15:0] v);
    case (k)
      0: return 16'(-v);
      1: return ~v;
      default: return {15'd0, v == 0};
    endcase
  endfunction

  // Model of a top/next pair over a circular spill array of D slots (R10)
  function automatic logic [15:0] fold_model(input int npush);
    int slot[D]; int t, n, sp;
    t = 0; n = 0; sp = 0;
    for (int i = 0; i < D; i++) slot[i] = 0;
    for (int k = 1; k <= npush; k++) begin
      slot[sp] = n; sp = (sp + 1) % D; n = t; t = k;
    end
    for (int j = 1; j < npush; j++) begin
      t = (n + t) & 16'hFFFF; sp = (sp + D - 1) % D; n = slot[sp];
    end
    return 16'(t);
  endfunction

  initial begin
    logic [15:0] a, b, v;
    int k, s0;
    void'($urandom(32'd20240611));

    // R1 reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_data reset", out_data[15:0] | out_data[127:112], 16'h0);
    chk("R1 out_stb reset", {8'd0, out_stb}, 16'h0);

    // R2 immediate sign extension, R1 start at 0
    prog = '{16'h1FFB, 16'hF041, 16'h17FF, 16'hF042, 16'h4004};
    run_prog(8);
    chk("R2 pushi negative", port(1), 16'hFFFB);
    chk("R2 pushi positive", port(2), 16'h07FF);

    // R2/R12 memory push and pop via preloaded data
    wr(200, 16'hBEEF);
    prog = '{16'h20C8, 16'h30D2, 16'h20D2, 16'hF043, 16'h4004};
    run_prog(8);
    chk("R2 push/pop memory", port(3), 16'hBEEF);
    chk("R12 preload survives reset", port(3), 16'hBEEF);

    // R3 jz taken, tested entry consumed
    prog = '{16'h1007, 16'h1000, 16'h5006, 16'h1063, 16'hF041, 16'h4005, 16'hF040, 16'h4007};
    run_prog(10);
    chk("R3 jz taken consumes", port(0), 16'h0007);
    chk("R3 jz taken skips", port(1), 16'h0000);
    // R3 jnz not taken
    prog = '{16'h1007, 16'h1000, 16'h6006, 16'h1063, 16'hF041, 16'h4005, 16'hF040, 16'h4007};
    run_prog(10);
    chk("R3 jnz falls through", port(1), 16'h0063);
    chk("R3 jnz not taken", port(0), 16'h0000);
    // R3 jnz taken
    prog = '{16'h1007, 16'h1003, 16'h6006, 16'h1063, 16'hF041, 16'h4005, 16'hF040, 16'h4007};
    run_prog(10);
    chk("R3 jnz taken consumes", port(0), 16'h0007);

    // R4 random binary operations
    for (int it = 0; it < 64; it++) begin
      k = (it < 16) ? it : int'($urandom % 16);
      a = 16'($urandom);
      case ($urandom % 4)
        0: b = a;
        1: b = 16'($urandom % 20);
        default: b = 16'($urandom);
      endcase
      wr(200, a); wr(201, b);
      prog = '{16'h20C8, 16'h20C9, 16'hF000 | 16'(k), 16'hF040, 16'h4004};
      run_prog(8);
      chk($sformatf("R4 binary op %0d a=%h b=%h", k, a, b), port(0), ref_bin(k, a, b));
    end

    // R5 unary operations, including zero input
    for (int it = 0; it < 9; it++) begin
      v = (it < 3) ? 16'h0 : 16'($urandom);
      k = it % 3;
      wr(200, v);
      prog = '{16'h20C8, 16'hF010 | 16'(k), 16'hF045, 16'h4003};
      run_prog(6);
      chk($sformatf("R5 unary op %0d v=%h", k, v), port(5), ref_una(k, v));
    end

    // R6 store then load, store removes both entries
    prog = '{16'h1009, 16'h10DC, 16'h1055, 16'hF021, 16'h10DC, 16'hF020,
             16'hF043, 16'hF044, 16'h4008};
    run_prog(12);
    chk("R6 load after store", port(3), 16'h0055);
    chk("R6 store pops two", port(4), 16'h0009);

    // R7 poppc jump and pushpc value
    prog = '{16'h1005, 16'hF023, 16'h1001, 16'hF040, 16'h4004, 16'hF022, 16'hF041, 16'h4007};
    run_prog(8);
    chk("R7 pushpc next address", port(1), 16'h0006);
    chk("R7 poppc skipped code", port(0), 16'h0000);

    // R8 over, dup, drop, nip
    prog = '{16'h1001, 16'h1002, 16'hF026, 16'hF040, 16'hF024, 16'hF025, 16'hF027,
             16'hF041, 16'hF042, 16'h4009};
    run_prog(12);
    chk("R8 over copies next", port(0), 16'h0001);
    chk("R8 dup/drop/nip keeps top", port(1), 16'h0002);
    chk("R8 nip removed next", port(2), 16'h0000);

    // R9 input to output across random ports, single strobe
    for (int it = 0; it < 6; it++) begin
      int ni, no;
      ni = int'($urandom % 8); no = int'($urandom % 8);
      for (int p = 0; p < 8; p++) in_data[p*16 +: 16] = 16'($urandom);
      prog = '{16'hF030 | 16'(ni), 16'hF040 | 16'(no), 16'h4002};
      s0 = stb_cnt;
      run_prog(6);
      chk($sformatf("R9 in%0d to out%0d", ni, no), port(no), in_data[ni*16 +: 16]);
      chk("R9 one strobe per out", 16'(stb_cnt - s0), 16'd1);
    end

    // R10 full capacity and wrap past it
    for (int extra = 0; extra < 2; extra++) begin
      int np;
      np = D + 2 + extra;
      prog.delete();
      for (int i = 1; i <= np; i++) prog.push_back(16'h1000 | 16'(i));
      for (int i = 1; i < np; i++) prog.push_back(16'hF000);
      prog.push_back(16'hF040);
      prog.push_back(16'h4000 | 16'(prog.size()));
      run_prog(2 * np + 6);
      if (extra == 0) chk("R10 capacity LIFO sum", port(0), 16'(np * (np + 1) / 2));
      chk($sformatf("R10 fold of %0d pushes", np), port(0), fold_model(np));
    end

    // R13 reserved codes are no-operations
    prog = '{16'h1005, 16'h7123, 16'hE000, 16'hF0FF, 16'hF050, 16'hF038, 16'hF041, 16'h4007};
    run_prog(10);
    chk("R13 reserved codes ignored", port(1), 16'h0005);

    // R11 halt from reset, then mid-loop halt on a counter
    prog = '{16'h1000, 16'h1001, 16'hF000, 16'hF024, 16'hF040, 16'h4001};
    halt = 1'b1;
    foreach (prog[i]) wr(i, prog[i]);
    start(1'b1);
    s0 = stb_cnt;
    repeat (10) @(negedge clk);
    chk("R11 halted from reset no output", port(0), 16'h0000);
    chk("R11 halted from reset no strobe", 16'(stb_cnt - s0), 16'd0);
    halt = 1'b0;
    repeat (23) @(negedge clk);
    halt = 1'b1;
    v = port(0);
    chk("R11 count before halt", v, 16'd4);
    s0 = stb_cnt;
    repeat (10) @(negedge clk);
    chk("R11 frozen during halt", port(0), v);
    chk("R11 no strobe during halt", 16'(stb_cnt - s0), 16'd0);
    halt = 1'b0;
    repeat (10) @(negedge clk);
    halt = 1'b1;
    chk("R11 resumes after halt", port(0), 16'd6);

    // R12 preload wins over a core store in the same cycle
    prog = '{16'h10F0, 16'h1077, 16'hF021, 16'h20F0, 16'hF046, 16'h4005};
    foreach (prog[i]) wr(i, prog[i]);
    start(1'b0);
    @(negedge clk); @(negedge clk);
    pl_we = 1'b1; pl_addr = 8'hF0; pl_data = 16'h1234;
    @(negedge clk);
    pl_we = 1'b0;
    repeat (6) @(negedge clk);
    halt = 1'b1;
    chk("R12 preload priority", port(6), 16'h1234);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule